// File: doc/BRIEF.md
# Toggle-Based Event Pulse Synchronizer

This block moves single-cycle event strobes from one clock domain into a second, unrelated clock domain. The pulse itself never crosses. In the source domain every strobe flips a level register. That level is captured by a chain of destination-domain flip-flops. A change detector at the end of the chain turns each observed change back into a strobe exactly one destination clock wide. The block has no backpressure. When the source clock is faster than the destination clock, the user must space strobes so that each level change is held long enough for the chain to see it.

Each domain has its own reset input. The level register, every synchronizer stage and the change-detector register all clear to the same reset level. Because the destination-side flops are cleared by the destination reset, removing the two resets in either order cannot look like a level change, so no false strobe appears. The chain depth and the shared reset level are parameters.

Top module: `psync_pulse_xfer`

## Requirements
- R1: While `dst_rst_n` is low, `dst_pulse` is low.
- R2: When the source clock is faster than the destination clock and strobes are spaced by at least three destination periods, the number of `dst_pulse` strobes equals the number of `src_pulse` strobes.
- R3: When the source clock period is at least twice the destination period, `src_pulse` may stay high on consecutive source cycles, and each source cycle with `src_pulse` high yields one `dst_pulse` strobe.
- R4: Each output strobe is high for exactly one destination clock cycle.
- R5: An isolated input strobe appears at `dst_pulse` no sooner than SYNC_STAGES and no later than SYNC_STAGES+1 destination rising edges after the source edge that samples it.
- R6: With both resets asserted, releasing them in either order (source first or destination first) produces no `dst_pulse` strobe.
- R7: The parameter RST_LEVEL (0 or 1) sets the common reset value of the source level, the synchronizer stages and the change-detector register. R2 through R6 hold for both values and for any SYNC_STAGES of 2 or more (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain reset, active low, asynchronous assert |
| src_pulse | input | 1 | Event strobe, one source cycle per event |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain reset, active low, asynchronous assert |
| dst_pulse | output | 1 | Event strobe, one destination cycle per event |

## Verification
A wrong internal state shows at the output as a miscount. If the source level fails to flip, an event is lost. If a stage leaves reset at a value other than the source level, an extra strobe appears within SYNC_STAGES destination cycles of reset release. If the change-detector register is stuck or mis-reset, strobes are doubled, widened or missing on the very next change. The bench therefore compares strobe counts after each burst and after each staggered reset release. It also measures the edge distance of an isolated strobe and checks that no strobe is wider than one destination cycle.

// File: rtl/psync_pkg.sv
`timescale 1ps/1ps
package psync_pkg;

  // New source level after one source cycle: flips when an event arrives.
  function automatic logic toggle_next(input logic level, input logic event_in);
    return level ^ event_in;
  endfunction

  // A destination strobe is due when the synchronized level differs from
  // the level seen on the previous destination cycle.
  function automatic logic level_changed(input logic now_level, input logic last_level);
    return now_level ^ last_level;
  endfunction

endpackage

// File: rtl/psync_src_toggle.sv
`timescale 1ps/1ps
module psync_src_toggle #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  output logic level_out
);
  import psync_pkg::*;

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RST_LEVEL;
    else        level_q <= toggle_next(level_q, event_in);
  end

  assign level_out = level_q;
endmodule

// File: rtl/psync_sync_chain.sv
`timescale 1ps/1ps
module psync_sync_chain #(
  parameter int   STAGES    = 2,
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic d_in;
    if (s == 0) begin : g_first
      assign d_in = async_in;
    end else begin : g_next
      assign d_in = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_LEVEL;
      else        stg_q[s] <= d_in;
    end
  end

  assign sync_out = stg_q[LAST];
endmodule

// File: rtl/psync_edge_det.sv
`timescale 1ps/1ps
module psync_edge_det #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic last_level,
  output logic strobe
);
  import psync_pkg::*;

  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_LEVEL;
    else        last_q <= level_in;
  end

  assign last_level = last_q;
  assign strobe     = level_changed(level_in, last_q);
endmodule

// File: rtl/psync_pulse_xfer.sv
`timescale 1ps/1ps
module psync_pulse_xfer #(
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_LEVEL   = 1'b0
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  // Named internal events, visible to the bound checker.
  logic src_level;   // level that crosses the domain boundary
  logic sync_level;  // level at the end of the synchronizer chain
  logic prev_level;  // synchronized level one destination cycle earlier
  logic dst_edge;    // change seen at the end of the chain

  psync_src_toggle #(
    .RST_LEVEL (RST_LEVEL)
  ) src_tgl_i (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .event_in  (src_pulse),
    .level_out (src_level)
  );

  psync_sync_chain #(
    .STAGES    (SYNC_STAGES),
    .RST_LEVEL (RST_LEVEL)
  ) chain_i (
    .clk      (dst_clk),
    .rst_n    (dst_rst_n),
    .async_in (src_level),
    .sync_out (sync_level)
  );

  psync_edge_det #(
    .RST_LEVEL (RST_LEVEL)
  ) edge_i (
    .clk        (dst_clk),
    .rst_n      (dst_rst_n),
    .level_in   (sync_level),
    .last_level (prev_level),
    .strobe     (dst_edge)
  );

  assign dst_pulse = dst_edge;
endmodule

// File: rtl/psync_pulse_xfer_chk.sv
`timescale 1ps/1ps
module psync_pulse_xfer_chk #(
  parameter logic RST_LEVEL = 1'b0
) (
  input logic src_clk,
  input logic src_rst_n,
  input logic src_pulse,
  input logic src_level,
  input logic dst_clk,
  input logic dst_rst_n,
  input logic dst_pulse,
  input logic sync_level,
  input logic prev_level
);

  AST_QUIET_IN_RESET: assert property (@(posedge dst_clk)
    !dst_rst_n |-> !dst_pulse); // R1

  AST_SRC_FLIP_ON_EVENT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_pulse |=> (src_level != $past(src_level))); // R2

  AST_SRC_HOLD_IDLE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_pulse |=> $stable(src_level)); // R3

  AST_STROBE_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse); // R4

  AST_DST_RESET_LEVEL: assert property (@(posedge dst_clk)
    !dst_rst_n |-> (sync_level == RST_LEVEL && prev_level == RST_LEVEL)); // R6

endmodule

bind psync_pulse_xfer psync_pulse_xfer_chk #(
  .RST_LEVEL (RST_LEVEL)
) chk_i (
  .src_clk    (src_clk),
  .src_rst_n  (src_rst_n),
  .src_pulse  (src_pulse),
  .src_level  (src_level),
  .dst_clk    (dst_clk),
  .dst_rst_n  (dst_rst_n),
  .dst_pulse  (dst_pulse),
  .sync_level (sync_level),
  .prev_level (prev_level)
);

// File: tb/psync_pulse_xfer_tb_top.sv
`timescale 1ps/1ps
module psync_pulse_xfer_tb_top;

  localparam int ST_A = 2;
  localparam int ST_B = 3;

  // Stimulus rows: src half period (ps), dst half period (ps), strobes, spacing in src cycles
  localparam int NROW = 4;
  localparam int VEC [NROW][4] = '{
    '{2500, 2500, 20, 6},   // equal rates, spaced            R2
    '{1000, 2500, 20, 10},  // fast source, spaced            R2
    '{6500, 2500, 30, 1},   // slow source, every cycle       R3
    '{7300, 2500, 25, 1}    // slower source, every cycle     R3
  };

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b1, dst_rst_n = 1'b1;
  logic src_pulse = 1'b0;
  logic pulse_a, pulse_b;
  int   src_half = 2500, dst_half = 2500;
  bit   clk_on = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int cnt_a = 0, cnt_b = 0, wide_a = 0, wide_b = 0;
  logic last_a = 1'b0, last_b = 1'b0;
  int dst_edges = 0;

  psync_pulse_xfer #(.SYNC_STAGES(ST_A), .RST_LEVEL(1'b0)) dut_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_pulse(src_pulse),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_pulse(pulse_a));

  psync_pulse_xfer #(.SYNC_STAGES(ST_B), .RST_LEVEL(1'b1)) dut2_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_pulse(src_pulse),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_pulse(pulse_b));

  initial begin
    #500;
    clk_on = 1'b1;
    forever begin #(src_half); src_clk = ~src_clk; end
  end
  initial begin
    #1734;
    forever begin #(dst_half); dst_clk = ~dst_clk; end
  end

  always @(posedge dst_clk) dst_edges++;

  always @(negedge dst_clk) begin
    if (pulse_a) cnt_a++;
    if (pulse_b) cnt_b++;
    if (pulse_a && last_a) wide_a++;
    if (pulse_b && last_b) wide_b++;
    last_a = pulse_a;
    last_b = pulse_b;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge dst_clk);
    cnt_a = 0; cnt_b = 0; wide_a = 0; wide_b = 0;
  endtask

  task automatic wait_dst(input int n);
    for (int i = 0; i < n; i++) @(negedge dst_clk);
  endtask

  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge src_clk) src_pulse = 1'b1;
      for (int g = 1; g < gap; g++) @(negedge src_clk) src_pulse = 1'b0;
    end
    @(negedge src_clk) src_pulse = 1'b0;
  endtask

  task automatic full_reset();
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    wait_dst(4);
    src_rst_n = 1'b1;
    wait_dst(2);
    dst_rst_n = 1'b1;
    wait_dst(4);
  endtask

  initial begin
    #1;
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    wait (clk_on);
    wait_dst(3);
    // R1: reset state
    chk(!pulse_a, "R1 dut_i pulse in reset", int'(pulse_a), 0);
    chk(!pulse_b, "R1 dut2_i pulse in reset", int'(pulse_b), 0);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    wait_dst(4);

    // Table walk: counts must match for both depths / reset levels (R2, R3, R7)
    for (int r = 0; r < NROW; r++) begin
      src_half = VEC[r][0];
      dst_half = VEC[r][1];
      full_reset();
      clear_counts();
      send(VEC[r][2], VEC[r][3]);
      wait_dst(20);
      chk(cnt_a == VEC[r][2], (VEC[r][3] == 1) ? "R3 dut_i count" : "R2 dut_i count",
          cnt_a, VEC[r][2]);
      chk(cnt_b == VEC[r][2], "R7 dut2_i count", cnt_b, VEC[r][2]);
      chk(wide_a == 0 && wide_b == 0, "R4 strobe wider than one cycle",
          wide_a + wide_b, 0);
    end

    // R5: latency of an isolated strobe
    src_half = 2500; dst_half = 2500;
    full_reset();
    begin
      int snap, lat_a, lat_b;
      lat_a = -1; lat_b = -1;
      @(negedge src_clk) src_pulse = 1'b1;
      @(posedge src_clk);
      #1 snap = dst_edges;
      @(negedge src_clk) src_pulse = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge dst_clk);
        #1;
        if (pulse_a && lat_a < 0) lat_a = dst_edges - snap;
        if (pulse_b && lat_b < 0) lat_b = dst_edges - snap;
      end
      chk(lat_a >= ST_A && lat_a <= ST_A + 1, "R5 dut_i latency", lat_a, ST_A);
      chk(lat_b >= ST_B && lat_b <= ST_B + 1, "R5 dut2_i latency", lat_b, ST_B);
    end

    // R6: leave an odd number of events in flight, then staggered releases
    send(3, 8);
    #3000;
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    wait_dst(2);
    chk(!pulse_a && !pulse_b, "R1 pulse while both in reset",
        int'(pulse_a) + int'(pulse_b), 0);
    clear_counts();
    src_rst_n = 1'b1;               // source first
    wait_dst(10);
    dst_rst_n = 1'b1;
    wait_dst(12);
    chk(cnt_a == 0, "R6 src-first release dut_i", cnt_a, 0);
    chk(cnt_b == 0, "R7 src-first release dut2_i", cnt_b, 0);

    send(5, 8);
    #3000;
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    wait_dst(2);
    clear_counts();
    dst_rst_n = 1'b1;               // destination first
    wait_dst(10);
    src_rst_n = 1'b1;
    wait_dst(12);
    chk(cnt_a == 0, "R6 dst-first release dut_i", cnt_a, 0);
    chk(cnt_b == 0, "R7 dst-first release dut2_i", cnt_b, 0);

    // After the reset sequence, events still pass one for one
    clear_counts();
    send(4, 8);
    wait_dst(15);
    chk(cnt_a == 4 && cnt_b == 4, "R2 count after staggered release",
        cnt_a + cnt_b, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule